// File: doc/BRIEF.md
# Register Branch-and-Exchange Unit

This unit handles the register-indirect branch of a 16-bit compressed instruction set, in both its plain form and its form with link. A decode stage presents one halfword with its own address. The unit names a source register on a register-file read port, and it takes the returned value in the same cycle. One clock later it delivers four results: the new program counter, the instruction-set state that the branch selects, an optional write to the link register, and a flag for outcomes the architecture leaves undefined.

Bit 0 of the source value selects the state. A 1 keeps the 16-bit compressed state, and a 0 selects the 32-bit state. The target address is the source value with bit 0 cleared. Register 15 is not read from the register file. It is formed as the instruction address plus 4, which is the value the program counter shows in compressed code. The unit flags the undefined cases and does not try to repair them.

The register file, pipeline control and fetch redirection are outside the unit.

Top module: `rbx_unit`

## Requirements
- R1: An instruction whose bits 15..8 equal 8'h47, presented with `in_valid`, raises `out_valid` for one cycle on the next clock edge. Any other halfword never raises `out_valid` or `link_we`.
- R2: `rf_raddr` is combinational and equals {insn[6], insn[5:3]}. The value of insn[2:0] has no effect on any output.
- R3: `tgt_pc` equals the source value with bit 0 forced to 0. `narrow_mode` equals bit 0 of the source value, where 1 means the 16-bit state and 0 means the 32-bit state.
- R4: When insn[7] is 1 (linked form), `link_we` rises together with `out_valid`, and `link_data` is (instruction address + 2) with bit 0 set. When insn[7] is 0, `link_we` stays low.
- R5: A source value whose bits [1:0] equal 2'b10 sets `unpred`.
- R6: When the source register is 15, the source value is the instruction address + 4, and `rf_rdata` is ignored. A word-aligned address therefore gives `tgt_pc` = address + 4 with `narrow_mode` = 0, and a halfword-aligned address sets `unpred`.
- R7: The linked form with source register 15 sets `unpred`.
- R8: With `rst` high at a clock edge, every registered output becomes 0.
- R9: A cycle without `in_valid` leads to `out_valid` = 0 and `link_we` = 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Halfword on `insn` is to be executed |
| insn | input | 16 | Instruction halfword |
| insn_addr | input | 32 | Byte address of the instruction |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data for `rf_raddr` |
| out_valid | output | 1 | One-cycle strobe: results below are valid |
| tgt_pc | output | 32 | Branch target address |
| narrow_mode | output | 1 | New state: 1 = 16-bit, 0 = 32-bit |
| link_we | output | 1 | Link register write enable |
| link_data | output | 32 | Link register write value |
| unpred | output | 1 | Undefined outcome detected |

## Verification
The read index `rf_raddr` is due in the same cycle as the instruction, so the bench samples it a moment after driving the inputs. Every other result passes through one register stage and is due after exactly one rising edge. The bench drives each instruction on a falling edge, lets one rising edge pass, and compares at the next falling edge against values computed from its own register model. Directed cases then check that `out_valid` and `link_we` drop one edge after `in_valid` goes low.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

  // Opcode of bits [15:8]; bit 7 chooses plain (0) or linked (1) form.
  localparam logic [7:0] RBX_OPC = 8'h47;

  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_PLAIN = 2'd1,
    BR_LINK  = 2'd2
  } br_kind_e;

  // Low two bits 2'b10: target not word aligned while 32-bit state selected.
  function automatic logic misaligned_wide(input logic [1:0] lo);
    return (lo == 2'b10);
  endfunction

endpackage

// File: rtl/rbx_decode.sv
module rbx_decode
  import rbx_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int RIDX_W = 4
) (
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  output br_kind_e          kind,
  output logic [RIDX_W-1:0] ridx
);
  localparam int OPC_LSB  = INSN_W - 8;
  localparam int LINK_BIT = OPC_LSB - 1;
  localparam int HI_BIT   = LINK_BIT - 1;
  localparam int RM_LSB   = HI_BIT - (RIDX_W - 1);

  logic opc_hit;

  assign opc_hit = (insn[INSN_W-1:OPC_LSB] == RBX_OPC);

  // High register bit on top, low field below; trailing bits are ignored.
  assign ridx = {insn[HI_BIT], insn[HI_BIT-1:RM_LSB]};

  always_comb begin
    if (!in_valid || !opc_hit) kind = BR_NONE;
    else if (insn[LINK_BIT])   kind = BR_LINK;
    else                       kind = BR_PLAIN;
  end

endmodule

// File: rtl/rbx_operand.sv
module rbx_operand #(
  parameter int AW     = 32,
  parameter int RIDX_W = 4,
  parameter int PC_OFS = 4
) (
  input  logic [RIDX_W-1:0] ridx,
  input  logic [AW-1:0]     insn_addr,
  input  logic [AW-1:0]     rf_rdata,
  output logic [AW-1:0]     operand,
  output logic              pc_src
);
  localparam logic [RIDX_W-1:0] PC_IDX = {RIDX_W{1'b1}};
  localparam logic [AW-1:0]     OFS    = AW'(PC_OFS);

  assign pc_src  = (ridx == PC_IDX);
  assign operand = pc_src ? (insn_addr + OFS) : rf_rdata;

endmodule

// File: rtl/rbx_result.sv
module rbx_result
  import rbx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 2
) (
  input  br_kind_e      kind,
  input  logic          pc_src,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] insn_addr,
  output logic [AW-1:0] tgt,
  output logic          narrow,
  output logic [AW-1:0] link_val,
  output logic          undef
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic [AW-1:0] next_addr;

  assign next_addr = insn_addr + STEP;
  assign tgt       = {operand[AW-1:1], 1'b0};
  assign narrow    = operand[0];
  assign link_val  = {next_addr[AW-1:1], 1'b1};
  assign undef     = misaligned_wide(operand[1:0]) ||
                     ((kind == BR_LINK) && pc_src);

endmodule

// File: rtl/rbx_unit.sv
module rbx_unit
  import rbx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INSN_W     = 16,
  parameter int RIDX_W     = 4,
  parameter int PC_OFS     = 4,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [AW-1:0]     insn_addr,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [AW-1:0]     rf_rdata,
  output logic              out_valid,
  output logic [AW-1:0]     tgt_pc,
  output logic              narrow_mode,
  output logic              link_we,
  output logic [AW-1:0]     link_data,
  output logic              unpred
);
  br_kind_e      kind;
  logic [AW-1:0] operand;
  logic          pc_src;
  logic [AW-1:0] tgt_c;
  logic          narrow_c;
  logic [AW-1:0] link_c;
  logic          undef_c;

  rbx_decode #(.INSN_W(INSN_W), .RIDX_W(RIDX_W)) u_dec (
    .in_valid (in_valid),
    .insn     (insn),
    .kind     (kind),
    .ridx     (rf_raddr)
  );

  rbx_operand #(.AW(AW), .RIDX_W(RIDX_W), .PC_OFS(PC_OFS)) u_opnd (
    .ridx      (rf_raddr),
    .insn_addr (insn_addr),
    .rf_rdata  (rf_rdata),
    .operand   (operand),
    .pc_src    (pc_src)
  );

  rbx_result #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_res (
    .kind      (kind),
    .pc_src    (pc_src),
    .operand   (operand),
    .insn_addr (insn_addr),
    .tgt       (tgt_c),
    .narrow    (narrow_c),
    .link_val  (link_c),
    .undef     (undef_c)
  );

  // Single register stage; PC update and link write leave together.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      tgt_pc      <= '0;
      narrow_mode <= 1'b0;
      link_we     <= 1'b0;
      link_data   <= '0;
      unpred      <= 1'b0;
    end else begin
      out_valid <= (kind != BR_NONE);
      link_we   <= (kind == BR_LINK);
      if (kind != BR_NONE) begin
        tgt_pc      <= tgt_c;
        narrow_mode <= narrow_c;
        link_data   <= link_c;
        unpred      <= undef_c;
      end
    end
  end

endmodule

// File: rtl/rbx_unit_chk.sv
module rbx_unit_chk #(
  parameter int AW     = 32,
  parameter int INSN_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [INSN_W-1:0] insn,
  input logic              out_valid,
  input logic [AW-1:0]     tgt_pc,
  input logic              narrow_mode,
  input logic              link_we,
  input logic [AW-1:0]     link_data,
  input logic              unpred
);
  p_valid_cause_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && insn[INSN_W-1:INSN_W-8] == 8'h47));

  p_tgt_even_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !tgt_pc[0]);

  p_link_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
    link_we |-> out_valid);

  p_link_odd_r4: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_data[0]);

  p_misalign_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !narrow_mode && tgt_pc[1]) |-> unpred);

  p_idle_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !link_we));

endmodule

bind rbx_unit rbx_unit_chk #(.AW(AW), .INSN_W(INSN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .insn        (insn),
  .out_valid   (out_valid),
  .tgt_pc      (tgt_pc),
  .narrow_mode (narrow_mode),
  .link_we     (link_we),
  .link_data   (link_data),
  .unpred      (unpred)
);

// File: tb/test_rbx_unit.sv
module test_rbx_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] insn;
  logic [31:0] insn_addr;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        out_valid;
  logic [31:0] tgt_pc;
  logic        narrow_mode;
  logic        link_we;
  logic [31:0] link_data;
  logic        unpred;

  logic [31:0] regs [16];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign rf_rdata = regs[rf_raddr];

  rbx_unit i_rbx_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .insn_addr(insn_addr), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .out_valid(out_valid), .tgt_pc(tgt_pc), .narrow_mode(narrow_mode),
    .link_we(link_we), .link_data(link_data), .unpred(unpred)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, wait one rising edge, compare at the next falling edge.
  task automatic run(input logic [15:0] i, input logic [31:0] a);
    logic        hit, lnk, e_un;
    logic [3:0]  idx;
    logic [31:0] src;
    @(negedge clk);
    in_valid = 1'b1; insn = i; insn_addr = a;
    hit = (i[15:8] == 8'h47);
    lnk = i[7];
    idx = {i[6], i[5:3]};
    src = (idx == 4'd15) ? a + 32'd4 : regs[idx];
    e_un = (src[1:0] == 2'b10) || (lnk && idx == 4'd15);
    #1 chk("R2 rf_raddr", 32'(rf_raddr), 32'(idx));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid", 32'(out_valid), 32'(hit));
    chk("R4 link_we", 32'(link_we), 32'(hit && lnk));
    if (hit) begin
      chk("R3/R6 tgt_pc", tgt_pc, {src[31:1], 1'b0});
      chk("R3 narrow_mode", 32'(narrow_mode), 32'(src[0]));
      chk("R5/R7 unpred", 32'(unpred), 32'(e_un));
      if (lnk) chk("R4 link_data", link_data, (a + 32'd2) | 32'd1);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) regs[k] = 32'hDEAD_0000 + 32'(k);
    rst = 1'b1; in_valid = 1'b0; insn = '0; insn_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 out_valid", 32'(out_valid), 0);
    chk("R8 tgt_pc", tgt_pc, 0);
    chk("R8 link_we", 32'(link_we), 0);
    chk("R8 link_data", link_data, 0);
    chk("R8 unpred", 32'(unpred), 0);
    chk("R8 narrow_mode", 32'(narrow_mode), 0);
    rst = 1'b0;

    // Directed corners
    regs[3] = 32'h0000_1001;  run(16'h4718, 32'h100);  // R3 plain, narrow state
    regs[3] = 32'h0000_2000;  run(16'h4798, 32'h200);  // R4 linked, wide aligned
    regs[9] = 32'h0000_300A;  run(16'h4748, 32'h300);  // R5 misaligned, high reg
    run(16'h4778, 32'h400);                            // R6 R15 word aligned
    run(16'h4778, 32'h402);                            // R6 R15 halfword aligned
    run(16'h47F8, 32'h500);                            // R7 linked R15
    regs[2] = 32'h0000_4001;  run(16'h4717, 32'h600);  // R2 trailing bits ignored
    run(16'h4618, 32'h700);                            // R1 other opcode
    // R9 idle cycle drops strobes
    regs[1] = 32'h0000_5001;  run(16'h4788, 32'h800);
    @(negedge clk);
    chk("R9 out_valid idle", 32'(out_valid), 0);
    chk("R9 link_we idle", 32'(link_we), 0);

    // Constrained random
    for (int n = 0; n < 300; n++) begin
      logic [15:0] ri;
      for (int k = 0; k < 15; k++) regs[k] = $urandom;
      ri = 16'($urandom);
      if ($urandom_range(9) < 7) ri[15:8] = 8'h47;
      run(ri, {$urandom} & 32'hFFFF_FFFE);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule